// File: doc/BRIEF.md
# Banked Register File with Status Register

This block keeps the programmer-visible register state of a 32-bit CISC-style processor. It holds eight data registers, seven general address registers and two stack pointers, one for user mode and one for supervisor mode. Address register 7 names whichever stack pointer the privilege bit of the 16-bit status register currently selects. Every access carries an operand size of 1, 2 or 4 bytes. A read returns only the low part of the register, zero-extended. A narrow write replaces only the low byte or low half-word and keeps the upper bits.

The read port is combinational and shows the state before the next clock edge. A write takes effect at that edge. The status register has three update paths: a full-word load, a load of the 3-bit interrupt level, and a set/clear pair for each individual flag. When a request is malformed, the block reports it on an error pin and ignores it. Instruction decode and arithmetic belong to other blocks. The ports are plain control and data pins with no handshake: each access completes in a single cycle and can never be stalled.

Top module: `cpurf_top`

## Requirements
- R1: After reset, every data register, every address register and both stack pointers read zero, and `sr` is 0x2700 (supervisor bit 13 set, interrupt level 7 in bits 10:8, all other bits clear).
- R2: A 4-byte write with `wr_bank`=0 (data) or 1 (address) and `wr_idx` 0–7 stores `wr_data` in that register. A read of the same bank, index and size 4 returns the value from the cycle after the write.
- R3: A read with `rd_size` 1 returns bits 7:0 of the register, and size 2 returns bits 15:0. In both cases the upper bits of `rd_data` are zero.
- R4: A write of size 1 replaces only bits 7:0 of the target, and size 2 replaces only bits 15:0. The remaining upper bits keep their previous value.
- R5: Address index 7 reaches the supervisor stack pointer when `sr[13]` is 1 and the user stack pointer when it is 0, for both reads and writes. A write uses the value `sr[13]` holds before the edge, even if the same edge changes that bit.
- R6: A write changes exactly one register. Every other data register, address register and stack pointer keeps its value.
- R7: When a write has an index of 8 or more, or a size other than 1, 2 or 4, `wr_err` is 1 in that cycle and no register changes. A read with the same kind of fault sets `rd_err` and returns zero.
- R8: `flag_set[k]` sets and `flag_clr[k]` clears one status bit, with k mapped as 0→bit 0 (carry), 1→bit 1 (overflow), 2→bit 2 (zero), 3→bit 3 (negative), 4→bit 4 (extend), 5→bit 13 (supervisor), 6→bit 15 (trace). No other bit changes. If set and clear are both raised for the same k, set wins.
- R9: `ipl_wr_en` loads `ipl_val` into `sr[10:8]` and leaves the other 13 bits unchanged.
- R10: `sr_wr_en` loads all 16 bits from `sr_wr_data`. When several status updates arrive in one cycle, they apply in this order: the full-word load first, then the level field, then the flag clears, then the flag sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write request |
| wr_bank | input | 1 | Write bank: 0 data, 1 address |
| wr_idx | input | 4 | Write register index |
| wr_size | input | 3 | Write operand size in bytes |
| wr_data | input | 32 | Write value |
| wr_err | output | 1 | Current write request is malformed and ignored |
| rd_bank | input | 1 | Read bank: 0 data, 1 address |
| rd_idx | input | 4 | Read register index |
| rd_size | input | 3 | Read operand size in bytes |
| rd_data | output | 32 | Zero-extended read value |
| rd_err | output | 1 | Current read request is malformed |
| sr_wr_en | input | 1 | Full status word load |
| sr_wr_data | input | 16 | Status word value |
| ipl_wr_en | input | 1 | Interrupt level load |
| ipl_val | input | 3 | New interrupt level |
| flag_set | input | 7 | Per-flag set strobes |
| flag_clr | input | 7 | Per-flag clear strobes |
| sr | output | 16 | Current status register |

## Verification
A write to address index 7 and a flip of the supervisor bit can happen in the same cycle. The bench provokes this by raising a stack-pointer write together with the supervisor clear strobe. It then judges the result by reading index 7 under both privilege settings: the value must appear only in the stack pointer that the old privilege selected. A second collision is tested by putting a full-word status load, a level load and flag strobes on one edge and comparing `sr` with the result the stated order produces.

// File: rtl/cpurf_pkg.sv
package cpurf_pkg;

  localparam int SR_W      = 16;
  localparam int NUM_FLAGS = 7;
  localparam int SUP_BIT   = 13;
  localparam int IPL_LO    = 8;
  localparam int IPL_W     = 3;
  localparam logic [SR_W-1:0] SR_RESET = 16'h2700;

  typedef enum logic [2:0] {
    SZ_BYTE = 3'd1,
    SZ_HALF = 3'd2,
    SZ_FULL = 3'd4
  } opsize_e;

  function automatic logic size_ok(input logic [2:0] sz);
    return (sz == SZ_BYTE) || (sz == SZ_HALF) || (sz == SZ_FULL);
  endfunction

  // strobe index -> status bit position
  function automatic int flag_pos(input int k);
    case (k)
      5:       return SUP_BIT;
      6:       return 15;
      default: return k;
    endcase
  endfunction

endpackage

// File: rtl/cpurf_slot_dec.sv
module cpurf_slot_dec #(
  parameter int NUM_D = 8,
  parameter int NUM_A = 8,
  parameter int IDXW  = 4,
  localparam int NSLOT = NUM_D + NUM_A + 1
) (
  input  logic             en,
  input  logic             bank,
  input  logic [IDXW-1:0]  idx,
  input  logic [2:0]       size,
  input  logic             sup,
  output logic [NSLOT-1:0] hit,
  output logic             err
);
  import cpurf_pkg::*;

  logic in_range;
  logic ok;

  always_comb begin
    if (bank) in_range = (idx < IDXW'(NUM_A));
    else      in_range = (idx < IDXW'(NUM_D));
  end

  assign ok  = en && in_range && size_ok(size);
  assign err = en && !(in_range && size_ok(size));

  genvar g;
  generate
    for (g = 0; g < NUM_D; g++) begin : g_data
      assign hit[g] = ok && !bank && (idx == IDXW'(g));
    end
    for (g = 0; g < NUM_A - 1; g++) begin : g_addr
      assign hit[NUM_D + g] = ok && bank && (idx == IDXW'(g));
    end
  endgenerate

  assign hit[NSLOT-2] = ok && bank && (idx == IDXW'(NUM_A - 1)) && !sup;
  assign hit[NSLOT-1] = ok && bank && (idx == IDXW'(NUM_A - 1)) &&  sup;

endmodule

// File: rtl/cpurf_status.sv
module cpurf_status
  import cpurf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sr_wr_en,
  input  logic [SR_W-1:0]      sr_wr_data,
  input  logic                 ipl_wr_en,
  input  logic [IPL_W-1:0]     ipl_val,
  input  logic [NUM_FLAGS-1:0] flag_set,
  input  logic [NUM_FLAGS-1:0] flag_clr,
  output logic [SR_W-1:0]      sr_q
);

  logic [SR_W-1:0] base;
  logic [SR_W-1:0] with_ipl;
  logic [SR_W-1:0] clr_mask;
  logic [SR_W-1:0] set_mask;
  logic [SR_W-1:0] sr_d;

  assign base = sr_wr_en ? sr_wr_data : sr_q;

  always_comb begin
    with_ipl = base;
    if (ipl_wr_en) with_ipl[IPL_LO +: IPL_W] = ipl_val;
  end

  genvar k;
  generate
    for (k = 0; k < SR_W; k++) begin : g_mask
      always_comb begin
        clr_mask[k] = 1'b0;
        set_mask[k] = 1'b0;
        for (int f = 0; f < NUM_FLAGS; f++) begin
          if (flag_pos(f) == k) begin
            clr_mask[k] = flag_clr[f];
            set_mask[k] = flag_set[f];
          end
        end
      end
    end
  endgenerate

  assign sr_d = (with_ipl & ~clr_mask) | set_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) sr_q <= SR_RESET;
    else        sr_q <= sr_d;
  end

endmodule

// File: rtl/cpurf_top.sv
module cpurf_top #(
  parameter int XLEN  = 32,
  parameter int NUM_D = 8,
  parameter int NUM_A = 8,
  localparam int IDXW  = $clog2(NUM_D) + 1,
  localparam int NSLOT = NUM_D + NUM_A + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_bank,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [2:0]      wr_size,
  input  logic [XLEN-1:0] wr_data,
  output logic            wr_err,
  input  logic            rd_bank,
  input  logic [IDXW-1:0] rd_idx,
  input  logic [2:0]      rd_size,
  output logic [XLEN-1:0] rd_data,
  output logic            rd_err,
  input  logic            sr_wr_en,
  input  logic [15:0]     sr_wr_data,
  input  logic            ipl_wr_en,
  input  logic [2:0]      ipl_val,
  input  logic [6:0]      flag_set,
  input  logic [6:0]      flag_clr,
  output logic [15:0]     sr
);
  import cpurf_pkg::*;

  logic [NSLOT-1:0]           wr_hit;
  logic [NSLOT-1:0]           rd_hit;
  logic [NSLOT-1:0][XLEN-1:0] slot_q;
  logic [XLEN-1:0]            rd_raw;
  logic [SR_W-1:0]            sr_q;

  function automatic logic [XLEN-1:0] merge_low(input logic [XLEN-1:0] old_v,
                                                input logic [XLEN-1:0] new_v,
                                                input logic [2:0]      sz);
    case (sz)
      SZ_BYTE: return {old_v[XLEN-1:8],  new_v[7:0]};
      SZ_HALF: return {old_v[XLEN-1:16], new_v[15:0]};
      default: return new_v;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] trim_low(input logic [XLEN-1:0] v,
                                               input logic [2:0]      sz);
    case (sz)
      SZ_BYTE: return {{(XLEN-8){1'b0}},  v[7:0]};
      SZ_HALF: return {{(XLEN-16){1'b0}}, v[15:0]};
      default: return v;
    endcase
  endfunction

  cpurf_slot_dec #(.NUM_D(NUM_D), .NUM_A(NUM_A), .IDXW(IDXW)) u_wdec (
    .en   (wr_en),
    .bank (wr_bank),
    .idx  (wr_idx),
    .size (wr_size),
    .sup  (sr_q[SUP_BIT]),
    .hit  (wr_hit),
    .err  (wr_err)
  );

  cpurf_slot_dec #(.NUM_D(NUM_D), .NUM_A(NUM_A), .IDXW(IDXW)) u_rdec (
    .en   (1'b1),
    .bank (rd_bank),
    .idx  (rd_idx),
    .size (rd_size),
    .sup  (sr_q[SUP_BIT]),
    .hit  (rd_hit),
    .err  (rd_err)
  );

  genvar s;
  generate
    for (s = 0; s < NSLOT; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n)         slot_q[s] <= '0;
        else if (wr_hit[s]) slot_q[s] <= merge_low(slot_q[s], wr_data, wr_size);
      end
    end
  endgenerate

  always_comb begin
    rd_raw = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (rd_hit[i]) rd_raw = rd_raw | slot_q[i];
    end
  end

  assign rd_data = trim_low(rd_raw, rd_size);

  cpurf_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .sr_wr_en   (sr_wr_en),
    .sr_wr_data (sr_wr_data),
    .ipl_wr_en  (ipl_wr_en),
    .ipl_val    (ipl_val),
    .flag_set   (flag_set),
    .flag_clr   (flag_clr),
    .sr_q       (sr_q)
  );

  assign sr = sr_q;

endmodule

// File: rtl/cpurf_chk.sv
module cpurf_chk #(
  parameter int XLEN  = 32,
  parameter int NSLOT = 17,
  parameter int IDXW  = 4,
  localparam int SLW  = $clog2(NSLOT)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic                       wr_err,
  input logic                       wr_bank,
  input logic [IDXW-1:0]            wr_idx,
  input logic [2:0]                 wr_size,
  input logic                       ipl_wr_en,
  input logic [2:0]                 ipl_val,
  input logic [6:0]                 flag_set,
  input logic [15:0]                sr,
  input logic [NSLOT-1:0][XLEN-1:0] slots
);

  logic [NSLOT-1:0][XLEN-1:0] prev_q;
  logic [NSLOT-1:0]           moved;
  logic                       seen_q;
  logic [SLW-1:0]             wslot;

  assign wslot = SLW'(wr_idx[IDXW-2:0]);

  always_ff @(posedge clk) begin
    prev_q <= slots;
    seen_q <= rst_n;
  end

  always_comb begin
    for (int i = 0; i < NSLOT; i++) moved[i] = (slots[i] != prev_q[i]);
  end

  // R7
  bad_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_err) |=> $stable(slots));

  // R6
  single_slot_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> ($countones(moved) <= 1));

  // R4
  byte_merge_keeps_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_err && !wr_bank && wr_size == 3'd1)
      |=> (slots[$past(wslot)][XLEN-1:8] == $past(slots[wslot][XLEN-1:8])));

  // R8
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set[5] |=> sr[13]);

  // R9
  level_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ipl_wr_en |=> (sr[10:8] == $past(ipl_val)));

endmodule

bind cpurf_top cpurf_chk #(.XLEN(XLEN), .NSLOT(NSLOT), .IDXW(IDXW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_err    (wr_err),
  .wr_bank   (wr_bank),
  .wr_idx    (wr_idx),
  .wr_size   (wr_size),
  .ipl_wr_en (ipl_wr_en),
  .ipl_val   (ipl_val),
  .flag_set  (flag_set),
  .sr        (sr),
  .slots     (slot_q)
);

// File: tb/cpurf_top_tb.sv
`timescale 1ns/1ps
module cpurf_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_bank = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [2:0]  wr_size = '0;
  logic [31:0] wr_data = '0;
  logic        wr_err;
  logic        rd_bank = 1'b0;
  logic [3:0]  rd_idx = '0;
  logic [2:0]  rd_size = 3'd4;
  logic [31:0] rd_data;
  logic        rd_err;
  logic        sr_wr_en = 1'b0;
  logic [15:0] sr_wr_data = '0;
  logic        ipl_wr_en = 1'b0;
  logic [2:0]  ipl_val = '0;
  logic [6:0]  flag_set = '0;
  logic [6:0]  flag_clr = '0;
  logic [15:0] sr;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  cpurf_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_size(wr_size),
    .wr_data(wr_data), .wr_err(wr_err),
    .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_size(rd_size),
    .rd_data(rd_data), .rd_err(rd_err),
    .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
    .ipl_wr_en(ipl_wr_en), .ipl_val(ipl_val),
    .flag_set(flag_set), .flag_clr(flag_clr), .sr(sr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic b, input logic [3:0] i,
                        input logic [2:0] sz, input logic [31:0] exp);
    rd_bank = b; rd_idx = i; rd_size = sz;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic wr(input logic b, input logic [3:0] i, input logic [2:0] sz,
                    input logic [31:0] d, input logic exp_err, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_bank = b; wr_idx = i; wr_size = sz; wr_data = d;
    #1;
    chk(tag, {31'd0, wr_err}, {31'd0, exp_err});
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sr_op(input logic we, input logic [15:0] wd, input logic ie,
                       input logic [2:0] iv, input logic [6:0] fs, input logic [6:0] fc,
                       input logic [15:0] exp, input string tag);
    @(negedge clk);
    sr_wr_en = we; sr_wr_data = wd; ipl_wr_en = ie; ipl_val = iv;
    flag_set = fs; flag_clr = fc;
    @(negedge clk);
    sr_wr_en = 1'b0; ipl_wr_en = 1'b0; flag_set = '0; flag_clr = '0;
    #1;
    chk(tag, {16'd0, sr}, {16'd0, exp});
  endtask

  task automatic t_reset();
    chk("R1 sr reset", {16'd0, sr}, 32'h2700);
    for (int i = 0; i < 8; i++) begin
      rd_chk("R1 data zero", 1'b0, 4'(i), 3'd4, 32'h0);
      rd_chk("R1 addr zero", 1'b1, 4'(i), 3'd4, 32'h0);
    end
  endtask

  task automatic t_data();
    wr(1'b0, 4'd1, 3'd4, 32'hDEAD_0001, 1'b0, "R2 wr D1");
    wr(1'b0, 4'd3, 3'd4, 32'h1122_3344, 1'b0, "R2 wr D3");
    wr(1'b0, 4'd5, 3'd4, 32'hA5A5_5A5A, 1'b0, "R2 wr D5");
    rd_chk("R2 D3", 1'b0, 4'd3, 3'd4, 32'h1122_3344);
    rd_chk("R2 D5", 1'b0, 4'd5, 3'd4, 32'hA5A5_5A5A);
    rd_chk("R6 D1 untouched", 1'b0, 4'd1, 3'd4, 32'hDEAD_0001);
    rd_chk("R6 D4 untouched", 1'b0, 4'd4, 3'd4, 32'h0);
    rd_chk("R6 A5 untouched", 1'b1, 4'd5, 3'd4, 32'h0);
    wr(1'b1, 4'd2, 3'd4, 32'hCAFE_F00D, 1'b0, "R2 wr A2");
    rd_chk("R2 A2", 1'b1, 4'd2, 3'd4, 32'hCAFE_F00D);
    rd_chk("R6 D2 untouched", 1'b0, 4'd2, 3'd4, 32'h0);
  endtask

  task automatic t_trim();
    rd_chk("R3 byte read", 1'b0, 4'd3, 3'd1, 32'h0000_0044);
    rd_chk("R3 half read", 1'b0, 4'd3, 3'd2, 32'h0000_3344);
  endtask

  task automatic t_merge();
    wr(1'b0, 4'd3, 3'd1, 32'hFFFF_FFEE, 1'b0, "R4 byte wr");
    rd_chk("R4 byte merge", 1'b0, 4'd3, 3'd4, 32'h1122_33EE);
    wr(1'b0, 4'd3, 3'd2, 32'h0000_BEEF, 1'b0, "R4 half wr");
    rd_chk("R4 half merge", 1'b0, 4'd3, 3'd4, 32'h1122_BEEF);
    wr(1'b1, 4'd2, 3'd2, 32'hFFFF_1234, 1'b0, "R4 half wr A2");
    rd_chk("R4 half merge A2", 1'b1, 4'd2, 3'd4, 32'hCAFE_1234);
  endtask

  task automatic t_err();
    wr(1'b0, 4'd8, 3'd4, 32'h0BAD_0BAD, 1'b1, "R7 index 8 flagged");
    wr(1'b0, 4'd3, 3'd3, 32'h0BAD_0BAD, 1'b1, "R7 size 3 flagged");
    wr(1'b1, 4'd4, 3'd0, 32'h0BAD_0BAD, 1'b1, "R7 size 0 flagged");
    rd_chk("R7 D3 kept", 1'b0, 4'd3, 3'd4, 32'h1122_BEEF);
    rd_chk("R7 D0 kept", 1'b0, 4'd0, 3'd4, 32'h0);
    rd_chk("R7 A4 kept", 1'b1, 4'd4, 3'd4, 32'h0);
    rd_chk("R7 bad read zero", 1'b0, 4'd3, 3'd5, 32'h0);
    chk("R7 rd_err", {31'd0, rd_err}, 32'd1);
    rd_chk("R7 good read", 1'b0, 4'd3, 3'd4, 32'h1122_BEEF);
    chk("R7 rd_err clear", {31'd0, rd_err}, 32'd0);
  endtask

  task automatic t_bank();
    wr(1'b1, 4'd7, 3'd4, 32'h0000_5000, 1'b0, "R5 wr ssp");
    sr_op(1'b0, 16'h0, 1'b0, 3'd0, 7'h00, 7'h20, 16'h0700, "R8 clear S");
    rd_chk("R5 usp empty", 1'b1, 4'd7, 3'd4, 32'h0);
    wr(1'b1, 4'd7, 3'd4, 32'h0000_3000, 1'b0, "R5 wr usp");
    sr_op(1'b0, 16'h0, 1'b0, 3'd0, 7'h20, 7'h00, 16'h2700, "R8 set S");
    rd_chk("R5 ssp kept", 1'b1, 4'd7, 3'd4, 32'h0000_5000);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    wr_en = 1'b1; wr_bank = 1'b1; wr_idx = 4'd7; wr_size = 3'd4; wr_data = 32'h0000_7777;
    flag_clr = 7'h20;
    @(negedge clk);
    wr_en = 1'b0; flag_clr = '0;
    #1;
    chk("R5 S cleared", {31'd0, sr[13]}, 32'd0);
    rd_chk("R5 usp unchanged", 1'b1, 4'd7, 3'd4, 32'h0000_3000);
    sr_op(1'b0, 16'h0, 1'b0, 3'd0, 7'h20, 7'h00, 16'h2700, "R8 S back");
    rd_chk("R5 ssp took write", 1'b1, 4'd7, 3'd4, 32'h0000_7777);
  endtask

  task automatic t_flags();
    sr_op(1'b0, 16'h0, 1'b0, 3'd0, 7'h45, 7'h00, 16'hA705, "R8 set C Z T");
    sr_op(1'b0, 16'h0, 1'b0, 3'd0, 7'h00, 7'h04, 16'hA701, "R8 clear Z");
    sr_op(1'b0, 16'h0, 1'b0, 3'd0, 7'h1A, 7'h01, 16'hA71A, "R8 V N X set, C clr");
    sr_op(1'b0, 16'h0, 1'b0, 3'd0, 7'h01, 7'h01, 16'hA71B, "R8 set wins");
  endtask

  task automatic t_ipl();
    sr_op(1'b0, 16'h0, 1'b1, 3'd3, 7'h00, 7'h00, 16'hA31B, "R9 level 3");
    sr_op(1'b0, 16'h0, 1'b1, 3'd0, 7'h00, 7'h00, 16'hA01B, "R9 level 0");
  endtask

  task automatic t_full();
    sr_op(1'b1, 16'h1234, 1'b0, 3'd0, 7'h00, 7'h00, 16'h1234, "R10 full load");
    sr_op(1'b1, 16'h0000, 1'b1, 3'd5, 7'h01, 7'h00, 16'h0501, "R10 order load+level+set");
    sr_op(1'b1, 16'hFFFF, 1'b1, 3'd2, 7'h00, 7'h40, 16'h7AFF, "R10 order load+level+clr");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_data();
    t_trim();
    t_merge();
    t_err();
    t_bank();
    t_same_cycle();
    t_flags();
    t_ipl();
    t_full();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule